// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register side of a general-purpose I/O controller: up to 128 pins grouped into four banks of 32. A simple synchronous register bus (address, write strobe, write data, read strobe, read data) reaches the per-bank pin-direction word, the output latch and two words of stored alternate-function selection. Firmware changes output levels only through dedicated set and clear words, so single pins can be toggled without a read-modify-write. The block drives a per-pin output value and output enable, and it folds output latch and sampled pad inputs into one pin-level readback word.

Edge detection and interrupts sit in a neighbouring block. That block watches the one-cycle strobe that marks each pin-level read. The alternate-function words are only stored and read back. The register map is sparse. Banks 0 to 2 share one low region. Bank 3's level, direction, set and clear words are placed 0x100 above bank 0's words. The eight alternate-function words fill their own run of addresses.

Top module: `gpio_bank_regfile`

## Requirements
- R1: Pin number p lives in bank p>>5 at bit p&31; on the pin ports it is bit p, so bank b occupies bits [32b+31:32b].
- R2: Writing a bank's direction word stores it; pin_oe for each pin equals its direction bit (1 = output), and the word reads back unchanged.
- R3: A write to a bank's set word ORs the data into the output latch; a write to its clear word clears each latch bit where the data holds a 1.
- R4: pin_out of each pin is its output latch bit ANDed with its direction bit, so a pin set as input drives 0.
- R5: The pin-level word reads the latch bit where the direction bit is 1 and the sampled pad input where it is 0; pad inputs pass through one sampling register (default SYNC_STAGES = 1) before they are visible.
- R6: Reading a set word returns the data last written to it; reading a clear word returns the constant CLR_READ_VAL (default 0x5A5A0000).
- R7: Byte offsets, banks 0/1/2/3: level 0x000/0x004/0x008/0x100, direction 0x00C/0x010/0x014/0x10C, set 0x018/0x01C/0x020/0x118, clear 0x024/0x028/0x02C/0x124.
- R8: Alternate-function low words sit at 0x054/0x05C/0x064/0x06C and high words at 0x058/0x060/0x068/0x070 for banks 0..3; each stores its 32-bit write and reads it back.
- R9: Any access at offset 0x200 or higher changes nothing, reads as 0 and raises no error pulse.
- R10: A read or write below 0x200 that hits no word above (including offsets with bits [1:0] non-zero) reads as 0, changes nothing, and sets bad_addr_pulse high for exactly the next cycle.
- R11: level_rd_pulse is high for one cycle, the cycle in which the data of a pin-level read is presented, and at no other time.
- R12: Reset clears direction, output latch, set readback and alternate-function words, so all pins come up as inputs with pin_out and pin_oe at 0.
- R13: bus_rdata carries the read data in the cycle after bus_rd is sampled high and is 0 in every cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W (12) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read strobe |
| pin_in | input | NUM_BANKS*DATA_W (128) | Pad input levels |
| pin_out | output | NUM_BANKS*DATA_W (128) | Driven pin values |
| pin_oe | output | NUM_BANKS*DATA_W (128) | Per-pin output enables |
| level_rd_pulse | output | 1 | One-cycle marker of a pin-level read |
| bad_addr_pulse | output | 1 | One-cycle marker of an unmapped access below 0x200 |

## Verification
A decode slip shows up in the next bus cycle as the wrong word answering an offset. The cause may be a bank 3 word landing in the low region, a set word acting as a clear, or a bank index off by one. It also changes pin_oe or pin_out at once, on the edge that takes the write. A corrupted latch or direction bit reaches the pins in that same cycle and the level readback in the next read. A stuck or missing strobe is seen on the read's data cycle. Sweeping every word offset below the window limit after each phase, and walking a single driven pin across all 128 positions, exposes each of these within one or two cycles of the faulty access.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

   // Register kind selected by an offset
   typedef enum logic [2:0] {
      RK_NONE  = 3'd0,
      RK_LEVEL = 3'd1,
      RK_DIR   = 3'd2,
      RK_SET   = 3'd3,
      RK_CLR   = 3'd4,
      RK_AFL   = 3'd5,
      RK_AFH   = 3'd6
   } reg_kind_e;

   typedef struct packed {
      reg_kind_e  kind;
      logic [1:0] bank;
   } reg_sel_t;

   // Number of per-bank word groups that are spaced bank-interleaved
   localparam int unsigned QUAD_KINDS = 4;

   // Kind of a bank-interleaved word group, ordered by address
   function automatic reg_kind_e quad_kind(input int unsigned q);
      case (q)
         0:       return RK_LEVEL;
         1:       return RK_DIR;
         2:       return RK_SET;
         3:       return RK_CLR;
         default: return RK_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_rf_decode.sv
module gpio_rf_decode
   import gpio_rf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_BANKS = 4,
   parameter int unsigned WIN_BYTES = 512,
   parameter int unsigned HI_BASE   = 256,
   parameter int unsigned AF_BASE   = 84
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel,
   output logic              in_win
);

   localparam int unsigned LO_BANKS = 3;
   localparam int unsigned LO_WORDS = LO_BANKS * QUAD_KINDS;
   localparam int unsigned HI_WORD0 = HI_BASE / 4;
   localparam int unsigned AF_WORD0 = AF_BASE / 4;
   localparam int unsigned AF_WORDS = 2 * 4;

   always_comb begin
      int unsigned wi;
      int unsigned rel;
      sel.kind = RK_NONE;
      sel.bank = 2'd0;
      wi       = 32'(addr) >> 2;
      rel      = 0;
      in_win   = (32'(addr) < WIN_BYTES);
      if (in_win && (addr[1:0] == 2'b00)) begin
         if (wi < LO_WORDS) begin
            sel.kind = quad_kind(wi / LO_BANKS);
            sel.bank = 2'(wi % LO_BANKS);
         end else if ((wi >= AF_WORD0) && (wi < AF_WORD0 + AF_WORDS)) begin
            rel      = wi - AF_WORD0;
            sel.kind = rel[0] ? RK_AFH : RK_AFL;
            sel.bank = 2'(rel >> 1);
         end else if ((wi >= HI_WORD0) && (wi < HI_WORD0 + LO_WORDS)) begin
            rel = wi - HI_WORD0;
            if ((rel % LO_BANKS) == 0) begin
               sel.kind = quad_kind(rel / LO_BANKS);
               sel.bank = 2'd3;
            end
         end
      end
      if (32'(sel.bank) >= NUM_BANKS) begin
         sel.kind = RK_NONE;
      end
   end

endmodule

// File: rtl/gpio_rf_bank.sv
module gpio_rf_bank #(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pin_in,
   input  logic              we_dir,
   input  logic              we_set,
   input  logic              we_clr,
   input  logic              we_afl,
   input  logic              we_afh,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] out_q,
   output logic [DATA_W-1:0] set_q,
   output logic [DATA_W-1:0] afl_q,
   output logic [DATA_W-1:0] afh_q,
   output logic [DATA_W-1:0] level
);

   logic [DATA_W-1:0] in_s;

   // Input sampling depth picked by parameter
   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) in_s <= '0;
         else        in_s <= pin_in;
      end
   end else begin : g_sync2
      logic [DATA_W-1:0] in_m;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_m <= '0;
            in_s <= '0;
         end else begin
            in_m <= pin_in;
            in_s <= in_m;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
         set_q <= '0;
         afl_q <= '0;
         afh_q <= '0;
      end else begin
         if (we_dir) dir_q <= wdata;
         if (we_set) begin
            out_q <= out_q | wdata;
            set_q <= wdata;
         end else if (we_clr) begin
            out_q <= out_q & ~wdata;
         end
         if (we_afl) afl_q <= wdata;
         if (we_afh) afh_q <= wdata;
      end
   end

   assign level = (out_q & dir_q) | (in_s & ~dir_q);

   // R3
   set_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_set |=> ((out_q & $past(wdata)) == $past(wdata)));

   // R3
   clr_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_clr && !we_set) |=> ((out_q & $past(wdata)) == '0));

   // R2
   dir_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_dir |=> (dir_q == $past(wdata)));

   // R6
   set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we_set |=> $stable(set_q));

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
   import gpio_rf_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned NUM_BANKS    = 4,
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned SYNC_STAGES  = 1,
   parameter logic [31:0] CLR_READ_VAL = 32'h5A5A_0000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_wr,
   input  logic [DATA_W-1:0]             bus_wdata,
   input  logic                          bus_rd,
   output logic [DATA_W-1:0]             bus_rdata,
   input  logic [NUM_BANKS*DATA_W-1:0]   pin_in,
   output logic [NUM_BANKS*DATA_W-1:0]   pin_out,
   output logic [NUM_BANKS*DATA_W-1:0]   pin_oe,
   output logic                          level_rd_pulse,
   output logic                          bad_addr_pulse
);

   localparam int unsigned BIDX_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int unsigned WIN      = 512;

   // Elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_width
      $error("gpio_bank_regfile: DATA_W must be 32");
   end
   if ((NUM_BANKS < 1) || (NUM_BANKS > 4)) begin : g_bad_banks
      $error("gpio_bank_regfile: NUM_BANKS must be 1..4");
   end
   if (ADDR_W < 10) begin : g_bad_addr
      $error("gpio_bank_regfile: ADDR_W must reach the 0x200 window");
   end
   if ((SYNC_STAGES < 1) || (SYNC_STAGES > 2)) begin : g_bad_sync
      $error("gpio_bank_regfile: SYNC_STAGES must be 1 or 2");
   end

   reg_sel_t          sel;
   logic              in_win;
   logic [BIDX_W-1:0] bidx;

   logic [DATA_W-1:0] dir_a [NUM_BANKS];
   logic [DATA_W-1:0] out_a [NUM_BANKS];
   logic [DATA_W-1:0] set_a [NUM_BANKS];
   logic [DATA_W-1:0] afl_a [NUM_BANKS];
   logic [DATA_W-1:0] afh_a [NUM_BANKS];
   logic [DATA_W-1:0] lvl_a [NUM_BANKS];
   logic [DATA_W-1:0] rd_val;

   gpio_rf_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_BANKS (NUM_BANKS),
      .WIN_BYTES (WIN),
      .HI_BASE   (256),
      .AF_BASE   (84)
   ) u_decode (
      .addr   (bus_addr),
      .sel    (sel),
      .in_win (in_win)
   );

   assign bidx = BIDX_W'(sel.bank);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic wr_hit;
      assign wr_hit = bus_wr && (sel.bank == 2'(b));

      gpio_rf_bank #(
         .DATA_W      (DATA_W),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_in (pin_in[b*DATA_W +: DATA_W]),
         .we_dir (wr_hit && (sel.kind == RK_DIR)),
         .we_set (wr_hit && (sel.kind == RK_SET)),
         .we_clr (wr_hit && (sel.kind == RK_CLR)),
         .we_afl (wr_hit && (sel.kind == RK_AFL)),
         .we_afh (wr_hit && (sel.kind == RK_AFH)),
         .wdata  (bus_wdata),
         .dir_q  (dir_a[b]),
         .out_q  (out_a[b]),
         .set_q  (set_a[b]),
         .afl_q  (afl_a[b]),
         .afh_q  (afh_a[b]),
         .level  (lvl_a[b])
      );

      assign pin_oe[b*DATA_W +: DATA_W]  = dir_a[b];
      assign pin_out[b*DATA_W +: DATA_W] = out_a[b] & dir_a[b];
   end

   always_comb begin
      rd_val = '0;
      case (sel.kind)
         RK_LEVEL: rd_val = lvl_a[bidx];
         RK_DIR:   rd_val = dir_a[bidx];
         RK_SET:   rd_val = set_a[bidx];
         RK_CLR:   rd_val = CLR_READ_VAL[DATA_W-1:0];
         RK_AFL:   rd_val = afl_a[bidx];
         RK_AFH:   rd_val = afh_a[bidx];
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata      <= '0;
         level_rd_pulse <= 1'b0;
         bad_addr_pulse <= 1'b0;
      end else begin
         bus_rdata      <= bus_rd ? rd_val : '0;
         level_rd_pulse <= bus_rd && (sel.kind == RK_LEVEL);
         bad_addr_pulse <= (bus_rd || bus_wr) && in_win && (sel.kind == RK_NONE);
      end
   end

   // R4
   pin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   // R9
   far_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !in_win) |=> (bus_rdata == '0));

   // R9
   far_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> !bad_addr_pulse);

   // R11
   level_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level_rd_pulse |-> $past(bus_rd));

   // R10
   bad_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_addr_pulse |-> $past(bus_rd || bus_wr));

   // R13
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/test_gpio_bank_regfile.sv
module test_gpio_bank_regfile;

   localparam int CLK_PERIOD = 10;
   localparam int NB   = 4;
   localparam int DW   = 32;
   localparam int AW   = 12;
   localparam int PINS = NB * DW;
   localparam logic [31:0] CLRV = 32'h5A5A_0000;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [AW-1:0]   bus_addr;
   logic            bus_wr;
   logic [DW-1:0]   bus_wdata;
   logic            bus_rd;
   logic [DW-1:0]   bus_rdata;
   logic [PINS-1:0] pin_in;
   logic [PINS-1:0] pin_out;
   logic [PINS-1:0] pin_oe;
   logic            level_rd_pulse;
   logic            bad_addr_pulse;

   int n_cmp = 0;
   int n_bad = 0;

   logic [31:0] m_dir [NB];
   logic [31:0] m_ol  [NB];
   logic [31:0] m_set [NB];
   logic [31:0] m_afl [NB];
   logic [31:0] m_afh [NB];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_bank_regfile i_gpio_bank_regfile (
      .clk            (clk),
      .rst_n          (rst_n),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_wdata      (bus_wdata),
      .bus_rd         (bus_rd),
      .bus_rdata      (bus_rdata),
      .pin_in         (pin_in),
      .pin_out        (pin_out),
      .pin_oe         (pin_oe),
      .level_rd_pulse (level_rd_pulse),
      .bad_addr_pulse (bad_addr_pulse)
   );

   // Offsets from R7 and R8
   function automatic int off_lvl(input int b); return (b == 3) ? 32'h100 : 4 * b; endfunction
   function automatic int off_dir(input int b); return off_lvl(b) + 32'h0C; endfunction
   function automatic int off_set(input int b); return off_lvl(b) + 32'h18; endfunction
   function automatic int off_clr(input int b); return off_lvl(b) + 32'h24; endfunction
   function automatic int off_afl(input int b); return 32'h54 + 8 * b; endfunction
   function automatic int off_afh(input int b); return 32'h58 + 8 * b; endfunction

   // {hit, is_level, data}
   function automatic logic [33:0] model_read(input int a);
      logic [31:0] pi;
      for (int b = 0; b < NB; b++) begin
         pi = pin_in[b*DW +: DW];
         if (a == off_lvl(b)) return {2'b11, (m_ol[b] & m_dir[b]) | (pi & ~m_dir[b])};
         if (a == off_dir(b)) return {2'b10, m_dir[b]};
         if (a == off_set(b)) return {2'b10, m_set[b]};
         if (a == off_clr(b)) return {2'b10, CLRV};
         if (a == off_afl(b)) return {2'b10, m_afl[b]};
         if (a == off_afh(b)) return {2'b10, m_afh[b]};
      end
      return 34'd0;
   endfunction

   task automatic model_write(input int a, input logic [31:0] d);
      for (int b = 0; b < NB; b++) begin
         if (a == off_dir(b)) m_dir[b] = d;
         if (a == off_set(b)) begin m_ol[b] = m_ol[b] | d; m_set[b] = d; end
         if (a == off_clr(b)) m_ol[b] = m_ol[b] & ~d;
         if (a == off_afl(b)) m_afl[b] = d;
         if (a == off_afh(b)) m_afh[b] = d;
      end
   endtask

   task automatic model_reset();
      for (int b = 0; b < NB; b++) begin
         m_dir[b] = '0; m_ol[b] = '0; m_set[b] = '0; m_afl[b] = '0; m_afh[b] = '0;
      end
   endtask

   task automatic chk(input string tag, input logic [PINS-1:0] act, input logic [PINS-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic bus_read(input int a, output logic [31:0] d, output logic s, output logic e);
      @(negedge clk);
      bus_addr = AW'(a);
      bus_rd   = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
      s = level_rd_pulse;
      e = bad_addr_pulse;
   endtask

   task automatic bus_write(input int a, input logic [31:0] d, output logic e);
      @(negedge clk);
      bus_addr  = AW'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      e = bad_addr_pulse;
      if (a < 32'h200) model_write(a, d);
   endtask

   function automatic logic [PINS-1:0] exp_oe();
      logic [PINS-1:0] v;
      for (int b = 0; b < NB; b++) v[b*DW +: DW] = m_dir[b];
      return v;
   endfunction

   function automatic logic [PINS-1:0] exp_out();
      logic [PINS-1:0] v;
      for (int b = 0; b < NB; b++) v[b*DW +: DW] = m_ol[b] & m_dir[b];
      return v;
   endfunction

   task automatic check_pins(input string tag);
      chk({tag, " R2 pin_oe"}, pin_oe, exp_oe());
      chk({tag, " R4 pin_out"}, pin_out, exp_out());
   endtask

   task automatic sweep();
      logic [31:0] d;
      logic s, e;
      logic [33:0] m;
      for (int w = 0; w < 128; w++) begin
         bus_read(w * 4, d, s, e);
         m = model_read(w * 4);
         chk("R5 R6 R7 R8 R10 rdata", PINS'(d), PINS'(m[31:0]));
         chk("R11 level strobe", PINS'(s), PINS'(m[32]));
         chk("R10 error pulse", PINS'(e), PINS'(!m[33]));
      end
      for (int k = 0; k < 3; k++) begin
         int a;
         a = (k == 0) ? 32'h001 : (k == 1) ? 32'h102 : 32'h05B;
         bus_read(a, d, s, e);
         chk("R10 misaligned rdata", PINS'(d), '0);
         chk("R10 misaligned error", PINS'(e), PINS'(1'b1));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic s, e;
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0; pin_in = '0;
      model_reset();
      repeat (3) @(negedge clk);
      // R12
      chk("R12 reset pin_oe", pin_oe, '0);
      chk("R12 reset pin_out", pin_out, '0);
      chk("R12 reset rdata", PINS'(bus_rdata), '0);
      rst_n = 1'b1;

      pin_in = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      repeat (3) @(negedge clk);
      sweep();

      // Register writes bank by bank: R2 R3 R4 R6 R8
      for (int b = 0; b < NB; b++) begin
         bus_write(off_dir(b), 32'hFF00_F0F0 ^ (32'h1111_1111 * b), e);
         check_pins("R2 dir");
         bus_write(off_set(b), 32'hAAAA_5555 ^ (32'h0303_0303 * b), e);
         check_pins("R3 set");
         bus_write(off_clr(b), 32'h0F0F_00FF, e);
         check_pins("R3 clr");
         bus_write(off_afl(b), 32'hC0DE_0000 + b, e);
         bus_write(off_afh(b), 32'hBEEF_0000 + (b << 4), e);
         chk("R8 af write no error", PINS'(e), '0);
      end
      sweep();

      pin_in = ~pin_in;
      repeat (3) @(negedge clk);
      sweep();

      // R13 idle
      bus_read(off_dir(1), d, s, e);
      @(negedge clk);
      chk("R13 idle rdata", PINS'(bus_rdata), '0);

      // R10 unmapped writes below 0x200
      for (int w = 0; w < 128; w++) begin
         logic [33:0] m;
         m = model_read(w * 4);
         if (!m[33]) begin
            bus_write(w * 4, 32'hFFFF_FFFF, e);
            chk("R10 unmapped write error", PINS'(e), PINS'(1'b1));
         end
      end
      bus_write(32'h10D, 32'hFFFF_FFFF, e);
      chk("R10 misaligned write error", PINS'(e), PINS'(1'b1));
      @(negedge clk);
      chk("R10 error pulse one cycle", PINS'(bad_addr_pulse), '0);
      check_pins("R10 after unmapped");
      sweep();

      // R9 far window
      for (int k = 0; k < 6; k++) begin
         int a;
         a = (k == 0) ? 32'h200 : (k == 1) ? 32'h300 : (k == 2) ? 32'h30C :
             (k == 3) ? 32'h318 : (k == 4) ? 32'h400 : 32'hFFC;
         bus_write(a, 32'hFFFF_FFFF, e);
         chk("R9 far write error", PINS'(e), '0);
         bus_read(a, d, s, e);
         chk("R9 far read data", PINS'(d), '0);
         chk("R9 far read error", PINS'(e), '0);
         chk("R9 far read strobe", PINS'(s), '0);
      end
      check_pins("R9 after far");
      sweep();

      // R1 walking driven pin
      for (int b = 0; b < NB; b++) bus_write(off_dir(b), 32'hFFFF_FFFF, e);
      for (int p = 0; p < PINS; p++) begin
         for (int b = 0; b < NB; b++) bus_write(off_clr(b), 32'hFFFF_FFFF, e);
         bus_write(off_set(p >> 5), 32'(1) << (p & 31), e);
         chk("R1 walking pin_out", pin_out, PINS'(1) << p);
      end
      // R4 input pins drive zero
      bus_write(off_set(2), 32'hFFFF_FFFF, e);
      bus_write(off_dir(2), 32'h0000_FFFF, e);
      chk("R4 input pins drive 0", pin_out, exp_out());

      // R12 second reset
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      model_reset();
      chk("R12 reset pin_oe", pin_oe, '0);
      chk("R12 reset pin_out", pin_out, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      sweep();

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule